// File: doc/BRIEF.md
# Operand Shifter with Carry-Out

This block sits in front of the second ALU operand and moves a 32-bit value left or right, or rotates it, within a single combinational pass. It is given the operand, a 3-bit shift kind, two possible shift amounts and the current carry flag. The two amounts are a 5-bit value from the instruction's immediate field and a full register value. A select input picks which amount applies. When the register amount is used, only its low 8 bits count, so amounts from 0 to 255 are possible.

Along with the shifted value, the block produces a carry-out. This is the last bit that left the operand during the shift. When nothing moves, the carry-out is the incoming carry flag. A rotate-extended kind moves the whole value one place to the right through the carry flag, which forms a 33-bit rotate. Register amounts of 32 or more give well-defined results for every kind.

Kind codes: 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right, 4 = rotate right extended, 5 = arithmetic left, 6 and 7 = reserved.

Top module: `opnd_shifter`

## Requirements
- R1: An effective amount of 0 with kind 0, 1, 2, 3 or 5 returns the operand unchanged and passes the carry flag to the carry-out.
- R2: Kind 0 with amount n from 1 to 31 shifts the operand left by n and puts zeros in the low n bits. The carry-out is operand bit 32-n.
- R3: Kind 1 with amount n from 1 to 31 shifts the operand right by n and puts zeros in the high n bits. The carry-out is operand bit n-1.
- R4: Kind 2 with amount n from 1 to 31 shifts the operand right by n and fills the high n bits with copies of operand bit 31. The carry-out is operand bit n-1.
- R5: Kind 3 with amount n from 1 to 31 rotates the operand right by n, so bits leaving bit 0 re-enter at bit 31 in order. The carry-out is result bit 31.
- R6: Kind 4 ignores the amount. The result is the carry flag in bit 31 followed by operand bits 31 down to 1, and the carry-out is operand bit 0.
- R7: Kind 5 behaves exactly like kind 0 for every amount.
- R8: When the register amount is selected, bits 31 to 8 of the register value have no effect on either output.
- R9: A register amount above 32 behaves as follows. Kinds 0 and 1 give a zero result with carry-out 0. Kind 2 gives 32 copies of operand bit 31 with carry-out operand bit 31. Kind 3 rotates by the amount modulo 32; when that is 0, the operand is returned and the carry-out is operand bit 31.
- R10: A register amount of exactly 32 behaves as follows. Kind 1 gives zero with carry-out operand bit 31. Kind 0 gives zero with carry-out operand bit 0. Kind 2 gives the sign fill with carry-out operand bit 31. Kind 3 returns the operand with carry-out operand bit 31.
- R11: Kinds 6 and 7 return the operand unchanged and pass the carry flag through.
- R12: When the immediate amount is selected (select input 0), the register value has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 32 | Value to be shifted |
| kind_i | input | 3 | Shift kind code |
| imm_amt_i | input | 5 | Amount from the immediate field |
| reg_amt_i | input | 32 | Register value supplying the amount |
| amt_from_reg_i | input | 1 | 1 selects the register amount, 0 the immediate |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The checker compares the outputs only when every input is a known 0 or 1. Because the block is purely combinational, it also relies on the inputs being steady at the moment it compares. The bench holds each input set for a full clock period and changes inputs only at the falling edge. It drives only the defined kind codes and the two reserved ones, always with known values, so every comparison the checker makes falls on a settled, fully known input set.

// File: rtl/opnd_shifter_pkg.sv
package opnd_shifter_pkg;

   typedef enum logic [2:0] {
      SK_LSL  = 3'd0,
      SK_LSR  = 3'd1,
      SK_ASR  = 3'd2,
      SK_ROR  = 3'd3,
      SK_RRX  = 3'd4,
      SK_ASL  = 3'd5,
      SK_RSV6 = 3'd6,
      SK_RSV7 = 3'd7
   } shift_kind_e;

endpackage

// File: rtl/osh_amt_sel.sv
// Chooses the effective shift amount from the immediate field or the low
// bits of a register value.
module osh_amt_sel #(
   parameter int IMM_W = 5,
   parameter int AMT_W = 8
) (
   input  logic [IMM_W-1:0] imm_i,
   input  logic [AMT_W-1:0] reg_low_i,
   input  logic             from_reg_i,
   output logic [AMT_W-1:0] amt_o
);
   if (IMM_W > AMT_W) begin : g_bad_widths
      $error("osh_amt_sel: IMM_W must not exceed AMT_W");
   end

   always_comb begin
      if (from_reg_i) amt_o = reg_low_i;
      else            amt_o = AMT_W'(imm_i);
   end
endmodule

// File: rtl/osh_bitrev.sv
// Reverses bit order; used to turn a right shifter into a left shifter.
module osh_bitrev #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] d_o
);
   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign d_o[b] = d_i[WIDTH-1-b];
   end
endmodule

// File: rtl/osh_rstages.sv
// Logarithmic right shifter: stage i moves by 2**i when its amount bit is
// set, filling from the low end (rotate) or from a fill bit.
module osh_rstages #(
   parameter int WIDTH = 32,
   localparam int LOG2W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] d_i,
   input  logic [LOG2W-1:0] k_i,
   input  logic             wrap_i,
   input  logic             fill_i,
   output logic [WIDTH-1:0] d_o
);
   logic [WIDTH-1:0] st [0:LOG2W];

   assign st[0] = d_i;

   for (genvar i = 0; i < LOG2W; i++) begin : g_stage
      localparam int S = 1 << i;
      logic [S-1:0] top_in;
      assign top_in    = wrap_i ? st[i][S-1:0] : {S{fill_i}};
      assign st[i+1]   = k_i[i] ? {top_in, st[i][WIDTH-1:S]} : st[i];
   end

   assign d_o = st[LOG2W];
endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
   import opnd_shifter_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int IMM_W = 5,
   parameter int AMT_W = 8,
   localparam int LOG2W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] operand_i,
   input  logic [2:0]       kind_i,
   input  logic [IMM_W-1:0] imm_amt_i,
   input  logic [WIDTH-1:0] reg_amt_i,
   input  logic             amt_from_reg_i,
   input  logic             carry_i,
   output logic [WIDTH-1:0] result_o,
   output logic             carry_o
);
   if ((1 << LOG2W) != WIDTH || WIDTH < 4) begin : g_bad_width
      $error("opnd_shifter: WIDTH must be a power of two, at least 4");
   end
   if (AMT_W <= LOG2W || AMT_W > WIDTH) begin : g_bad_amt
      $error("opnd_shifter: AMT_W must exceed log2(WIDTH) and fit the register");
   end

   shift_kind_e      kind;
   logic [AMT_W-1:0] amt;
   logic [LOG2W-1:0] k;
   logic [LOG2W-1:0] k_m1;
   logic             is_left;
   logic [WIDTH-1:0] rev_in;
   logic [WIDTH-1:0] eff_in;
   logic [WIDTH-1:0] core_out;
   logic [WIDTH-1:0] rev_out;
   logic [WIDTH-1:0] cand;
   logic             amt_zero;
   logic             amt_lt_w;
   logic             amt_eq_w;
   logic             unused_reg_hi;

   assign kind          = shift_kind_e'(kind_i);
   assign unused_reg_hi = ^reg_amt_i[WIDTH-1:AMT_W];

   osh_amt_sel #(.IMM_W(IMM_W), .AMT_W(AMT_W)) u_amt (
      .imm_i      (imm_amt_i),
      .reg_low_i  (reg_amt_i[AMT_W-1:0]),
      .from_reg_i (amt_from_reg_i),
      .amt_o      (amt)
   );

   assign k        = amt[LOG2W-1:0];
   assign k_m1     = k - LOG2W'(1);
   assign amt_zero = (amt == '0);
   assign amt_lt_w = (amt < AMT_W'(WIDTH));
   assign amt_eq_w = (amt == AMT_W'(WIDTH));
   assign is_left  = (kind == SK_LSL) || (kind == SK_ASL);

   osh_bitrev #(.WIDTH(WIDTH)) u_rev_in (
      .d_i (operand_i),
      .d_o (rev_in)
   );

   assign eff_in = is_left ? rev_in : operand_i;

   osh_rstages #(.WIDTH(WIDTH)) u_core (
      .d_i    (eff_in),
      .k_i    (k),
      .wrap_i (kind == SK_ROR),
      .fill_i ((kind == SK_ASR) & operand_i[WIDTH-1]),
      .d_o    (core_out)
   );

   osh_bitrev #(.WIDTH(WIDTH)) u_rev_out (
      .d_i (core_out),
      .d_o (rev_out)
   );

   assign cand = is_left ? rev_out : core_out;

   always_comb begin
      result_o = operand_i;
      carry_o  = carry_i;
      unique case (kind)
         SK_LSL, SK_ASL, SK_LSR: begin
            if (amt_zero) begin
               result_o = operand_i;
               carry_o  = carry_i;
            end else if (amt_lt_w) begin
               result_o = cand;
               carry_o  = eff_in[k_m1];
            end else if (amt_eq_w) begin
               result_o = '0;
               carry_o  = eff_in[WIDTH-1];
            end else begin
               result_o = '0;
               carry_o  = 1'b0;
            end
         end
         SK_ASR: begin
            if (amt_zero) begin
               result_o = operand_i;
               carry_o  = carry_i;
            end else if (amt_lt_w) begin
               result_o = cand;
               carry_o  = operand_i[k_m1];
            end else begin
               result_o = {WIDTH{operand_i[WIDTH-1]}};
               carry_o  = operand_i[WIDTH-1];
            end
         end
         SK_ROR: begin
            if (!amt_zero) begin
               result_o = cand;
               carry_o  = cand[WIDTH-1];
            end
         end
         SK_RRX: begin
            result_o = {carry_i, operand_i[WIDTH-1:1]};
            carry_o  = operand_i[0];
         end
         default: begin
            result_o = operand_i;
            carry_o  = carry_i;
         end
      endcase
   end
endmodule

// File: rtl/opnd_shifter_chk.sv
module opnd_shifter_chk #(
   parameter int WIDTH = 32,
   parameter int IMM_W = 5,
   parameter int AMT_W = 8
) (
   input logic [WIDTH-1:0] operand_i,
   input logic [2:0]       kind_i,
   input logic [IMM_W-1:0] imm_amt_i,
   input logic [WIDTH-1:0] reg_amt_i,
   input logic             amt_from_reg_i,
   input logic             carry_i,
   input logic [WIDTH-1:0] result_o,
   input logic             carry_o
);
   always_comb begin
      int unsigned n;
      int unsigned m;
      logic [WIDTH-1:0] exp_rot;
      if (!$isunknown({operand_i, kind_i, imm_amt_i, reg_amt_i,
                       amt_from_reg_i, carry_i})) begin
         n = amt_from_reg_i ? 32'(reg_amt_i[AMT_W-1:0]) : 32'(imm_amt_i);
         m = n % WIDTH;
         exp_rot = (m == 0) ? operand_i
                 : ((operand_i >> m) | (operand_i << (WIDTH - m)));

         if (n == 0 && kind_i != 3'd4 && kind_i < 3'd6) begin
            a_r1_zero_amt: assert (result_o == operand_i && carry_o == carry_i)
               else $error("R1 zero amount altered the operand or carry");
         end
         if ((kind_i == 3'd0 || kind_i == 3'd5) && n >= 1 && n <= WIDTH) begin
            a_r2_left_shift: assert (result_o == (operand_i << n)
                                     && carry_o == operand_i[WIDTH - n])
               else $error("R2 left shift result or carry wrong");
         end
         if (kind_i == 3'd1 && n >= 1 && n <= WIDTH) begin
            a_r3_right_logic: assert (result_o == (operand_i >> n)
                                      && carry_o == operand_i[n - 1])
               else $error("R3 logical right result or carry wrong");
         end
         if (kind_i == 3'd2 && n >= 1) begin
            a_r4_right_arith: assert (result_o == WIDTH'($signed(operand_i) >>> n)
                                      && carry_o == operand_i[(n < WIDTH) ? n - 1 : WIDTH - 1])
               else $error("R4 arithmetic right result or carry wrong");
         end
         if (kind_i == 3'd3 && n >= 1) begin
            a_r5_rotate: assert (result_o == exp_rot && carry_o == result_o[WIDTH-1])
               else $error("R5 rotate result or carry wrong");
         end
         if (kind_i == 3'd4) begin
            a_r6_rrx: assert (result_o == {carry_i, operand_i[WIDTH-1:1]}
                              && carry_o == operand_i[0])
               else $error("R6 rotate-extended result or carry wrong");
         end
         if ((kind_i == 3'd0 || kind_i == 3'd1 || kind_i == 3'd5) && n > WIDTH) begin
            a_r9_far_logic: assert (result_o == '0 && carry_o == 1'b0)
               else $error("R9 far logical shift not cleared");
         end
         if (kind_i >= 3'd6) begin
            a_r11_reserved: assert (result_o == operand_i && carry_o == carry_i)
               else $error("R11 reserved kind altered the operand");
         end
      end
   end
endmodule

bind opnd_shifter opnd_shifter_chk #(
   .WIDTH (WIDTH),
   .IMM_W (IMM_W),
   .AMT_W (AMT_W)
) u_chk (
   .operand_i      (operand_i),
   .kind_i         (kind_i),
   .imm_amt_i      (imm_amt_i),
   .reg_amt_i      (reg_amt_i),
   .amt_from_reg_i (amt_from_reg_i),
   .carry_i        (carry_i),
   .result_o       (result_o),
   .carry_o        (carry_o)
);

// File: tb/opnd_shifter_test.sv
`timescale 1ns/1ps
module opnd_shifter_test;

   typedef struct packed {
      logic [2:0]  kind;
      logic        from_reg;
      logic [4:0]  imm;
      logic [31:0] ramt;
      logic [31:0] op;
      logic        cin;
      logic [31:0] res;
      logic        co;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 26;
   localparam vec_t VT [NV] = '{
      '{3'd0, 1'b0, 5'd0,  32'h0,         32'h1234_5678, 1'b1, 32'h1234_5678, 1'b1, 8'd1 },  // R1
      '{3'd0, 1'b0, 5'd4,  32'h0,         32'hF000_000F, 1'b0, 32'h0000_00F0, 1'b1, 8'd2 },  // R2
      '{3'd1, 1'b0, 5'd4,  32'h0,         32'hF000_000F, 1'b0, 32'h0F00_0000, 1'b1, 8'd3 },  // R3
      '{3'd2, 1'b0, 5'd4,  32'h0,         32'h8000_0010, 1'b1, 32'hF800_0001, 1'b0, 8'd4 },  // R4
      '{3'd2, 1'b0, 5'd1,  32'h0,         32'h4000_0003, 1'b0, 32'h2000_0001, 1'b1, 8'd4 },  // R4
      '{3'd3, 1'b0, 5'd8,  32'h0,         32'h1234_5678, 1'b1, 32'h7812_3456, 1'b0, 8'd5 },  // R5
      '{3'd3, 1'b0, 5'd4,  32'h0,         32'h0000_0008, 1'b0, 32'h8000_0000, 1'b1, 8'd5 },  // R5
      '{3'd4, 1'b0, 5'd0,  32'h0,         32'h0000_0003, 1'b1, 32'h8000_0001, 1'b1, 8'd6 },  // R6
      '{3'd4, 1'b0, 5'd7,  32'h0,         32'h8000_0002, 1'b0, 32'h4000_0001, 1'b0, 8'd6 },  // R6
      '{3'd5, 1'b0, 5'd4,  32'h0,         32'hF000_000F, 1'b0, 32'h0000_00F0, 1'b1, 8'd7 },  // R7
      '{3'd1, 1'b1, 5'd0,  32'd32,        32'h8000_0000, 1'b0, 32'h0000_0000, 1'b1, 8'd10},  // R10
      '{3'd0, 1'b1, 5'd0,  32'd32,        32'h0000_0001, 1'b0, 32'h0000_0000, 1'b1, 8'd10},  // R10
      '{3'd1, 1'b1, 5'd0,  32'd33,        32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b0, 8'd9 },  // R9
      '{3'd0, 1'b1, 5'd0,  32'd40,        32'hFFFF_FFFF, 1'b1, 32'h0000_0000, 1'b0, 8'd9 },  // R9
      '{3'd2, 1'b1, 5'd0,  32'd200,       32'h8000_0000, 1'b0, 32'hFFFF_FFFF, 1'b1, 8'd9 },  // R9
      '{3'd2, 1'b1, 5'd0,  32'd32,        32'h7FFF_FFFF, 1'b1, 32'h0000_0000, 1'b0, 8'd10},  // R10
      '{3'd3, 1'b1, 5'd0,  32'd36,        32'h1234_5678, 1'b0, 32'h8123_4567, 1'b1, 8'd9 },  // R9
      '{3'd3, 1'b1, 5'd0,  32'd32,        32'h8000_0001, 1'b0, 32'h8000_0001, 1'b1, 8'd10},  // R10
      '{3'd1, 1'b1, 5'd0,  32'hFFFF_FF04, 32'hF000_000F, 1'b0, 32'h0F00_0000, 1'b1, 8'd8 },  // R8
      '{3'd0, 1'b1, 5'd0,  32'h0000_0100, 32'h1234_5678, 1'b0, 32'h1234_5678, 1'b0, 8'd8 },  // R8
      '{3'd6, 1'b0, 5'd4,  32'h0,         32'h1234_5678, 1'b1, 32'h1234_5678, 1'b1, 8'd11},  // R11
      '{3'd7, 1'b1, 5'd0,  32'd9,         32'hCAFE_0001, 1'b0, 32'hCAFE_0001, 1'b0, 8'd11},  // R11
      '{3'd3, 1'b1, 5'd0,  32'd0,         32'hABCD_0000, 1'b0, 32'hABCD_0000, 1'b0, 8'd1 },  // R1
      '{3'd1, 1'b0, 5'd31, 32'h0,         32'h8000_0000, 1'b1, 32'h0000_0001, 1'b0, 8'd3 },  // R3
      '{3'd0, 1'b0, 5'd31, 32'h0,         32'h0000_0003, 1'b0, 32'h8000_0000, 1'b1, 8'd2 },  // R2
      '{3'd1, 1'b0, 5'd4,  32'h0000_0001, 32'hF000_000F, 1'b0, 32'h0F00_0000, 1'b1, 8'd12}   // R12
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] operand_i = '0;
   logic [2:0]  kind_i = '0;
   logic [4:0]  imm_amt_i = '0;
   logic [31:0] reg_amt_i = '0;
   logic        amt_from_reg_i = 1'b0;
   logic        carry_i = 1'b0;
   logic [31:0] result_o;
   logic        carry_o;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   opnd_shifter uut (
      .operand_i      (operand_i),
      .kind_i         (kind_i),
      .imm_amt_i      (imm_amt_i),
      .reg_amt_i      (reg_amt_i),
      .amt_from_reg_i (amt_from_reg_i),
      .carry_i        (carry_i),
      .result_o       (result_o),
      .carry_o        (carry_o)
   );

   task automatic drive(input logic [2:0] kd, input logic fr, input logic [4:0] im,
                        input logic [31:0] ra, input logic [31:0] op, input logic ci);
      @(negedge clk);
      kind_i = kd; amt_from_reg_i = fr; imm_amt_i = im;
      reg_amt_i = ra; operand_i = op; carry_i = ci;
      #2;
   endtask

   task automatic check(input string tag, input logic [31:0] er, input logic ec);
      n_checks++;
      if (result_o !== er) begin
         n_fail++;
         $display("FAIL %s result actual=%h expected=%h", tag, result_o, er);
      end
      n_checks++;
      if (carry_o !== ec) begin
         n_fail++;
         $display("FAIL %s carry actual=%b expected=%b", tag, carry_o, ec);
      end
   endtask

   initial begin
      #2_000_000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R1: zero inputs during reset give zero result, carry from flag (0)
      check("R1 reset", 32'h0, 1'b0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         drive(VT[i].kind, VT[i].from_reg, VT[i].imm, VT[i].ramt, VT[i].op, VT[i].cin);
         check($sformatf("R%0d vec%0d", VT[i].req, i), VT[i].res, VT[i].co);
      end

      // R3 and R9: logical right sweep through the register amount
      for (int n = 0; n <= 40; n++) begin
         logic [31:0] op;
         logic [31:0] er;
         logic        ec;
         op = 32'hC3A5_5A3C;
         if (n == 0)       begin er = op;      ec = 1'b1;      end
         else if (n <= 32) begin er = op >> n; ec = op[n-1];   end
         else              begin er = '0;      ec = 1'b0;      end
         drive(3'd1, 1'b1, 5'd0, 32'(n), op, 1'b1);
         check($sformatf("R3/R9 lsr n=%0d", n), er, ec);
      end

      // R4 and R9: arithmetic right sweep, negative operand
      for (int n = 0; n <= 40; n++) begin
         logic [31:0] op;
         logic [31:0] er;
         logic        ec;
         op = 32'h9C3A_55A1;
         if (n == 0)      begin er = op; ec = 1'b0; end
         else if (n < 32) begin er = 32'($signed(op) >>> n); ec = op[n-1]; end
         else             begin er = 32'hFFFF_FFFF; ec = 1'b1; end
         drive(3'd2, 1'b1, 5'd0, 32'(n), op, 1'b0);
         check($sformatf("R4/R9 asr n=%0d", n), er, ec);
      end

      // R12: register value changes while immediate selected, outputs unchanged
      drive(3'd0, 1'b0, 5'd8, 32'hFFFF_FFFF, 32'h00AB_CDEF, 1'b0);
      check("R12 imm select", 32'hABCD_EF00, 1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule